// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block keeps a bank of 21 byte-wide control registers, numbered 0 to 20. An external host programs and inspects them over a two-wire serial bus that uses SMBus block framing at standard-mode rates. The rest of the chip sees every register at all times on one flat parallel bus. SCL and SDA arrive as raw pin levels and are oversampled in the system clock domain. The block answers through an open-drain enable: when that enable is 1, the pad pulls SDA low.

A write never carries a register address. After the bus address the host sends two framing bytes, which are discarded. Every later byte lands in the next register, counting up from register 0. A read returns a length byte and then registers 0 up to a limit held in register 8. Two register pairs, 11/12 and 13/14, are staged in shadow storage. Each pair reaches its live registers together, and only when both of its bytes arrive in one transaction. This keeps a multi-byte setting from ever being half applied.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The block acknowledges only the address byte 0xD2 (write) and the address byte 0xD3 (read). Any other address byte is not acknowledged, and the bytes that follow it until the next START have no effect on any register.
- R2: In a write, the first and second bytes after the address are acknowledged and then discarded. The k-th data byte after them (k counted from 0) loads register k, and every data byte is acknowledged.
- R3: A STOP or repeated START after some complete data bytes keeps those bytes. A byte that was cut off before its 8th bit changes nothing.
- R4: A read first sends the value of register 8 as the count byte. It then sends registers 0, 1, 2 and onward, each byte MSB first, and moves on to the next byte whenever the master acknowledges.
- R5: A write of 0x00 to register 8 is ignored, so register 8 is never zero.
- R6: Register 11 is loaded only when register 12 is written later in the same transaction, and then both change together. Registers 13 and 14 follow the same rule.
- R7: After reset, registers 1 to 6 hold 0xFF, register 8 holds 0x08, register 9 holds 0x10, and every other register holds 0x00.
- R8: Data bytes aimed past register 20 are acknowledged and discarded. Read bytes past register 20, or past the limit in register 8, are 0xFF.
- R9: The block changes its SDA drive only while SCL is low.
- R10: When the master does not acknowledge a read byte, the block releases SDA and sends nothing more until the next START.
- R11: A repeated START begins a new transaction. For example, a write address can be followed at once by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock level from the pad |
| sda_i | input | 1 | Serial data level from the pad, which is the wired-AND of all drivers |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| regs_o | output | 168 | All registers; register k sits at bits 8k+7 down to 8k |

## Verification
The assertions assume that SCL and SDA change slowly compared with clk_i. Each bus level must hold for several system clocks, so that every synchronized edge and every START or STOP arrives as a single clean pulse. The assertions also assume that the master never drives SDA while SCL is high, except to form a START or a STOP. The bench master holds every SCL phase for 20 system clocks and changes SDA only in the low phase. It also waits for the low phase to begin before it releases SDA after an acknowledge.

// File: rtl/cfg_smbus_pkg.sv
package cfg_smbus_pkg;
  localparam int NUM_REGS_DEF = 21;
  localparam int LIMIT_IDX    = 8;
  localparam int PAIR_BASE    = 11;
  localparam int NUM_PAIRS    = 2;
  localparam logic [7:0] WR_ADDR_DEF = 8'hD2;
  localparam logic [7:0] RD_ADDR_DEF = 8'hD3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_WAIT
  } bus_st_e;

  function automatic logic [7:0] reg_default(input int idx);
    if (idx >= 1 && idx <= 6) return 8'hFF;
    else if (idx == LIMIT_IDX) return 8'h08;
    else if (idx == 9) return 8'h10;
    else return 8'h00;
  endfunction

  function automatic bit is_pair_lo(input int idx);
    return idx >= PAIR_BASE && idx < PAIR_BASE + 2*NUM_PAIRS && ((idx - PAIR_BASE) % 2 == 0);
  endfunction

  function automatic bit is_pair_hi(input int idx);
    return idx >= PAIR_BASE && idx < PAIR_BASE + 2*NUM_PAIRS && ((idx - PAIR_BASE) % 2 == 1);
  endfunction
endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smbus_slave_fsm.sv
module smbus_slave_fsm
  import cfg_smbus_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = WR_ADDR_DEF,
  parameter logic [7:0] RD_ADDR = RD_ADDR_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] limit_i,
  input  logic [7:0] rd_byte_i,
  output logic [7:0] rd_ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic       txn_start_o,
  output logic       sda_oe_o
);
  bus_st_e    st_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, tx_q, pos_q, ptr_q;
  logic       addr_ph_q, rd_q, ack_q, mack_q;
  logic [7:0] rx_byte;

  assign rx_byte = {sh_q[6:0], sda_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      bit_q       <= '0;
      sh_q        <= '0;
      tx_q        <= '1;
      pos_q       <= '0;
      ptr_q       <= '0;
      addr_ph_q   <= 1'b0;
      rd_q        <= 1'b0;
      ack_q       <= 1'b0;
      mack_q      <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_idx_o    <= '0;
      wr_data_o   <= '0;
      txn_start_o <= 1'b0;
    end else begin
      wr_en_o     <= 1'b0;
      txn_start_o <= 1'b0;
      if (start_i) begin
        st_q        <= ST_RX;
        bit_q       <= '0;
        addr_ph_q   <= 1'b1;
        pos_q       <= '0;
        txn_start_o <= 1'b1;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_RX: begin
            if (scl_rise_i) begin
              sh_q  <= rx_byte;
              bit_q <= bit_q + 4'd1;
              if (bit_q == 4'd7) begin
                if (addr_ph_q) begin
                  ack_q <= (rx_byte == WR_ADDR) || (rx_byte == RD_ADDR);
                  rd_q  <= (rx_byte == RD_ADDR);
                end else begin
                  ack_q <= 1'b1;
                  // positions 0 and 1 are framing bytes
                  if (pos_q >= 8'd2) begin
                    wr_en_o   <= 1'b1;
                    wr_idx_o  <= pos_q - 8'd2;
                    wr_data_o <= rx_byte;
                  end
                  if (pos_q != 8'hFF) pos_q <= pos_q + 8'd1;
                end
              end
            end else if (scl_fall_i && bit_q == 4'd8) begin
              st_q <= ack_q ? ST_ACK : ST_WAIT;
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bit_q     <= '0;
              addr_ph_q <= 1'b0;
              if (rd_q) begin
                st_q  <= ST_TX;
                tx_q  <= limit_i;
                ptr_q <= '0;
              end else begin
                st_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_q <= bit_q + 4'd1;
            end else if (scl_fall_i) begin
              if (bit_q == 4'd8) begin
                st_q  <= ST_MACK;
                bit_q <= '0;
              end else begin
                tx_q <= {tx_q[6:0], 1'b1};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                st_q <= ST_TX;
                tx_q <= (ptr_q <= limit_i) ? rd_byte_i : 8'hFF;
                if (ptr_q != 8'hFF) ptr_q <= ptr_q + 8'd1;
              end else begin
                st_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_ptr_o = ptr_q;
  assign sda_oe_o = (st_q == ST_ACK) || (st_q == ST_TX && !tx_q[7]);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_smbus_pkg::*;
#(
  parameter int NUM_REGS = NUM_REGS_DEF,
  localparam int RW = NUM_REGS * 8,
  localparam int IW = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          txn_start_i,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_idx_i,
  input  logic [7:0]    wr_data_i,
  input  logic [7:0]    rd_ptr_i,
  output logic [7:0]    rd_byte_o,
  output logic [7:0]    limit_o,
  output logic [RW-1:0] regs_o
);
  logic [NUM_PAIRS-1:0] commit_w;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int LO = PAIR_BASE + 2*p;
    logic [7:0] shadow_q;
    logic       seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
        seen_q   <= 1'b0;
      end else if (txn_start_i) begin
        seen_q <= 1'b0;
      end else if (wr_en_i && wr_idx_i == 8'(LO)) begin
        shadow_q <= wr_data_i;
        seen_q   <= 1'b1;
      end
    end
    assign commit_w[p] = wr_en_i && (wr_idx_i == 8'(LO + 1)) && seen_q;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam bit IS_LO = is_pair_lo(r);
    localparam bit IS_HI = is_pair_hi(r);
    localparam int PI    = (IS_LO || IS_HI) ? (r - PAIR_BASE) / 2 : 0;
    logic [7:0] val_q;
    if (IS_LO) begin : g_lo
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) val_q <= reg_default(r);
        else if (commit_w[PI]) val_q <= g_pair[PI].shadow_q;
      end
    end else if (IS_HI) begin : g_hi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) val_q <= reg_default(r);
        else if (commit_w[PI]) val_q <= wr_data_i;
      end
    end else begin : g_plain
      logic zero_block;
      assign zero_block = (r == LIMIT_IDX) && (wr_data_i == 8'h00);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) val_q <= reg_default(r);
        else if (wr_en_i && wr_idx_i == 8'(r) && !zero_block) val_q <= wr_data_i;
      end
    end
    assign regs_o[r*8 +: 8] = val_q;
  end

  assign rd_byte_o = (rd_ptr_i < 8'(NUM_REGS)) ? regs_o[{rd_ptr_i[IW-1:0], 3'b000} +: 8] : 8'hFF;
  assign limit_o   = regs_o[LIMIT_IDX*8 +: 8];
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
  import cfg_smbus_pkg::*;
#(
  parameter int NUM_REGS = NUM_REGS_DEF,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] WR_ADDR = WR_ADDR_DEF,
  parameter logic [7:0] RD_ADDR = RD_ADDR_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic       sda_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic       wr_en_w, txn_start_w;
  logic [7:0] wr_idx_w, wr_data_w, rd_ptr_w, rd_byte_w, limit_w;

  smbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_w),
    .scl_rise_o (scl_rise_w),
    .scl_fall_o (scl_fall_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  smbus_slave_fsm #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_i       (sda_w),
    .scl_rise_i  (scl_rise_w),
    .scl_fall_i  (scl_fall_w),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .limit_i     (limit_w),
    .rd_byte_i   (rd_byte_w),
    .rd_ptr_o    (rd_ptr_w),
    .wr_en_o     (wr_en_w),
    .wr_idx_o    (wr_idx_w),
    .wr_data_o   (wr_data_w),
    .txn_start_o (txn_start_w),
    .sda_oe_o    (sda_oe_o)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .txn_start_i (txn_start_w),
    .wr_en_i     (wr_en_w),
    .wr_idx_i    (wr_idx_w),
    .wr_data_i   (wr_data_w),
    .rd_ptr_i    (rd_ptr_w),
    .rd_byte_o   (rd_byte_w),
    .limit_o     (limit_w),
    .regs_o      (regs_o)
  );
endmodule

// File: rtl/cfg_smbus_slave_chk.sv
module cfg_smbus_slave_chk
  import cfg_smbus_pkg::*;
#(
  parameter int NUM_REGS = NUM_REGS_DEF
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sda_oe_o,
  input logic [NUM_REGS*8-1:0] regs_o,
  input logic                  scl_fall_w,
  input logic                  stop_w,
  input logic                  wr_en_w,
  input logic [7:0]            wr_idx_w
);
  // R5
  limit_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_o[LIMIT_IDX*8 +: 8] != 8'h00);

  // R9
  drive_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_w));

  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> !sda_oe_o);

  // R6
  pair_a_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o[PAIR_BASE*8 +: 8] != $past(regs_o[PAIR_BASE*8 +: 8]))
      |-> $past(wr_en_w && wr_idx_w == 8'(PAIR_BASE + 1)));

  // R6
  pair_b_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o[(PAIR_BASE+2)*8 +: 8] != $past(regs_o[(PAIR_BASE+2)*8 +: 8]))
      |-> $past(wr_en_w && wr_idx_w == 8'(PAIR_BASE + 3)));

  // R2
  reg0_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o[7:0] != $past(regs_o[7:0])) |-> $past(wr_en_w && wr_idx_w == 8'd0));
endmodule

bind cfg_smbus_slave cfg_smbus_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_o   (sda_oe_o),
  .regs_o     (regs_o),
  .scl_fall_w (scl_fall_w),
  .stop_w     (stop_w),
  .wr_en_w    (wr_en_w),
  .wr_idx_w   (wr_idx_w)
);

// File: tb/cfg_smbus_slave_test.sv
`timescale 1ns/1ps
module cfg_smbus_slave_test;
  localparam int Q  = 20;
  localparam int NR = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int viol = 0;
  logic oe_prev = 1'b0;

  logic [7:0] model [NR];
  logic [7:0] wbuf [32];
  logic [7:0] sh_a, sh_b;

  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  cfg_smbus_slave uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  // R9 monitor: drive must not change during SCL high
  always @(negedge clk) begin
    if (rst_n && scl_m && (sda_oe !== oe_prev)) viol++;
    oe_prev = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; tick(Q);
      scl_m = 1'b1;   tick(Q);
      scl_m = 1'b0;
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    put_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q/2);
    ack = ~sda_line;
    tick(Q/2);
    scl_m = 1'b0;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q/2);
      b = {b[6:0], sda_line};
      tick(Q/2);
      scl_m = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0;
  endtask

  task automatic model_apply(input int n);
    for (int k = 0; k < n; k++) begin
      if (k == 8) begin
        if (wbuf[k] != 8'h00) model[k] = wbuf[k];
      end else if (k == 11) sh_a = wbuf[k];
      else if (k == 12) begin model[11] = sh_a; model[12] = wbuf[k]; end
      else if (k == 13) sh_b = wbuf[k];
      else if (k == 14) begin model[13] = sh_b; model[14] = wbuf[k]; end
      else if (k < NR) model[k] = wbuf[k];
    end
  endtask

  task automatic compare_all(input string tag);
    for (int r = 0; r < NR; r++) check8(tag, regs[r*8 +: 8], model[r]);
  endtask

  task automatic wr_head();
    logic a;
    bus_start();
    put_byte(8'hD2, a); check8("R1 write address ack", {7'd0, a}, 8'd1);
    put_byte(8'hC3, a); check8("R2 command ack", {7'd0, a}, 8'd1);
    put_byte(8'h7E, a); check8("R2 count ack", {7'd0, a}, 8'd1);
  endtask

  task automatic wr_txn(input int n);
    logic a;
    wr_head();
    for (int k = 0; k < n; k++) begin
      put_byte(wbuf[k], a);
      check8(k > 20 ? "R8 data ack past end" : "R2 data ack", {7'd0, a}, 8'd1);
    end
    bus_stop();
    model_apply(n);
  endtask

  task automatic rd_txn(input int n);
    logic a;
    logic [7:0] b, e;
    bus_start();
    put_byte(8'hD3, a); check8("R1 read address ack", {7'd0, a}, 8'd1);
    get_byte(1'b1, b);  check8("R4 count byte", b, model[8]);
    for (int k = 0; k < n; k++) begin
      get_byte(k < n-1, b);
      e = (k < NR && k <= int'(model[8])) ? model[k] : 8'hFF;
      check8(k > 20 ? "R8 read past end" : "R4 read data", b, e);
    end
    tick(4);
    check8("R10 release after nack", {7'd0, sda_oe}, 8'd0);
    bus_stop();
  endtask

  task automatic t_reset();
    for (int r = 0; r < NR; r++) model[r] = ((r >= 1 && r <= 6) ? 8'hFF : (r == 8) ? 8'h08 : (r == 9) ? 8'h10 : 8'h00);
    compare_all("R7 reset value");
    check8("R7 idle drive", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    put_byte(8'hA4, a); check8("R1 foreign address nack", {7'd0, a}, 8'd0);
    put_byte(8'h00, a); check8("R1 ignored after nack", {7'd0, a}, 8'd0);
    put_byte(8'h99, a);
    bus_stop();
    compare_all("R1 registers untouched");
  endtask

  task automatic t_write_basic();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_txn(4);
    compare_all("R2 sequential load");
  endtask

  task automatic t_read_default();
    rd_txn(9);
  endtask

  task automatic t_limit_zero();
    for (int k = 0; k < 9; k++) wbuf[k] = 8'(8'h20 + k);
    wbuf[8] = 8'h00;
    wr_txn(9);
    check8("R5 zero limit ignored", regs[8*8 +: 8], 8'h08);
    compare_all("R5 bank after zero limit");
  endtask

  task automatic t_pairs();
    for (int k = 0; k < 15; k++) wbuf[k] = 8'(8'h40 + k);
    wbuf[8] = 8'h0A;
    wr_txn(12);
    check8("R6 lone first of pair", regs[11*8 +: 8], 8'h00);
    compare_all("R6 bank after half pair");
    for (int k = 0; k < 15; k++) wbuf[k] = 8'(8'h60 + k);
    wbuf[8] = 8'h0A;
    wr_txn(14);
    check8("R6 pair committed", regs[11*8 +: 8], 8'h6B);
    check8("R6 second pair waits", regs[13*8 +: 8], 8'h00);
    wr_txn(15);
    check8("R6 second pair committed", regs[13*8 +: 8], 8'h6D);
    compare_all("R6 bank after pairs");
  endtask

  task automatic t_abort();
    logic a;
    wr_head();
    put_byte(8'hA1, a); check8("R3 byte ack", {7'd0, a}, 8'd1);
    put_byte(8'hB2, a); check8("R3 byte ack", {7'd0, a}, 8'd1);
    put_bits(8'h0C, 3);
    bus_stop();
    model[0] = 8'hA1; model[1] = 8'hB2;
    compare_all("R3 stop mid byte");
  endtask

  task automatic t_rstart();
    logic a;
    logic [7:0] b;
    wr_head();
    put_byte(8'h5C, a); check8("R11 byte ack", {7'd0, a}, 8'd1);
    put_bits(8'h0F, 4);
    bus_start();
    model[0] = 8'h5C;
    put_byte(8'hD3, a); check8("R11 read after repeated start", {7'd0, a}, 8'd1);
    get_byte(1'b1, b);  check8("R11 count byte", b, model[8]);
    get_byte(1'b0, b);  check8("R11 first register", b, 8'h5C);
    tick(4);
    check8("R10 release after nack", {7'd0, sda_oe}, 8'd0);
    bus_stop();
    compare_all("R3 repeated start mid byte");
  endtask

  task automatic t_beyond();
    for (int k = 0; k < 23; k++) wbuf[k] = 8'(8'h80 + k);
    wbuf[8] = 8'h19;
    wr_txn(23);
    compare_all("R8 writes past end dropped");
    rd_txn(26);
  endtask

  initial begin
    tick(10);
    rst_n = 1'b1;
    tick(10);
    t_reset();
    t_bad_addr();
    t_write_basic();
    t_read_default();
    t_limit_zero();
    t_pairs();
    t_abort();
    t_rstart();
    t_beyond();
    checks++;
    if (viol != 0) begin
      errors++;
      $display("FAIL R9 drive changed during SCL high actual %0d expected 0", viol);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule